// File: doc/BRIEF.md
# Fixed-Priority Interrupt Dispatcher

This block gathers single-cycle interrupt pulses from `N` hardware sources and turns them into task starts, one source at a time. Each pulse is held as a pending request. When nothing is running and no dispatch is in progress, the lowest-numbered pending source wins. After a fixed dispatch delay, a one-cycle trigger is issued for that source's task. The task then counts as busy until it finishes.

A task finishes in one of two ways, chosen by a parameter. In count mode it runs for a fixed number of cycles. In done mode it runs until its own done line is sampled high. A running task is never preempted. A request from a higher-priority source that arrives while a lower-priority task runs waits for that task to finish. The delays are expressed in clock cycles. For example, a 100 us dispatch delay and a 500 us run time at 10 MHz become 1000 and 5000 cycles.

Top module: `irq_dispatch`

## Requirements
- R1: A synchronous active-high reset clears all pending requests, the dispatch and run counters, every trigger and every busy output. A request accepted before reset is never dispatched after it.
- R2: The pulse is sampled on a clock edge while the block is idle. The trigger of that source then rises on the (LAT_CYC+1)-th rising edge after the sampling edge.
- R3: `task_trig` is one-hot or zero and lasts exactly one cycle. Bit i of `task_busy` rises only in the cycle in which bit i of `task_trig` is high.
- R4: In count mode (`USE_DONE`=0), a task's busy bit stays high for exactly RUN_CYC cycles. After that, the next pending request is triggered RUN_CYC+LAT_CYC+1 cycles after the previous trigger.
- R5: In done mode (`USE_DONE`=1), a task stays busy, independent of RUN_CYC, until `task_done` bit i of the running source i is sampled high. Busy then drops on the next edge. Done bits of other sources are ignored.
- R6: Sources are ranked by index, with index 0 highest. Simultaneous requests are triggered in ascending index order, one after another.
- R7: At most one busy bit is high at any time.
- R8: A running task is not preempted. A higher-priority request that arrives during a run is triggered only after the run ends, and the busy output keeps its value until then.
- R9: Repeated pulses from a source that is already pending merge into one request and produce one trigger.
- R10: The pending bit clears when its source wins arbitration. A new pulse from the same source during its own dispatch delay or run queues a further dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | N | Interrupt pulses, one per source; bit 0 has the highest priority |
| task_done | input | N | Task completion, one per source; used only in done mode |
| task_trig | output | N | One-cycle task start, one-hot |
| task_busy | output | N | High while the source's task runs |

## Verification
The checker watches several rules on every cycle:
- at most one busy bit is high;
- triggers are single-cycle and one-hot;
- busy rises only together with the matching trigger;
- busy does not change source mid-run;
- the run length stays within RUN_CYC in count mode;
- foreign done bits are ignored in done mode.

Priority order, the exact dispatch latency, merging of repeated pulses, re-queueing during a run and the loss of pending requests at reset all depend on what came before. These are shown only by the bench's scenarios. The bench compares the logged trigger sequence and the cycles on which the triggers occur against the values the requirements predict.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int N        = 4,
  parameter int LAT_CYC  = 1000,
  parameter int RUN_CYC  = 5000,
  parameter bit USE_DONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] task_done,
  output logic [N-1:0] task_trig,
  output logic [N-1:0] task_busy
);
  localparam int IW   = (N > 1) ? $clog2(N) : 1;
  localparam int MAXC = (LAT_CYC > RUN_CYC) ? LAT_CYC : RUN_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} state_t;

  state_t         st;
  logic [N-1:0]   pend;
  logic [IW-1:0]  cur, sel;
  logic [CW-1:0]  cnt;
  logic           hit, run_end;
  logic [N-1:0]   grant, cur_oh;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) sel = IW'(i);
  end

  assign hit     = |pend;
  assign grant   = (st == S_IDLE && hit) ? (N'(1) << sel) : '0;
  assign cur_oh  = N'(1) << cur;
  assign run_end = USE_DONE ? task_done[cur] : (cnt == '0);
  assign task_busy = (st == S_RUN) ? cur_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      st        <= S_IDLE;
      cur       <= '0;
      cnt       <= '0;
      task_trig <= '0;
    end else begin
      pend      <= (pend | irq) & ~grant;
      task_trig <= '0;
      case (st)
        S_IDLE: if (hit) begin
          cur <= sel;
          cnt <= CW'(LAT_CYC - 1);
          st  <= S_WAIT;
        end
        S_WAIT: if (cnt == '0) begin
          cnt       <= CW'(RUN_CYC - 1);
          task_trig <= cur_oh;
          st        <= S_RUN;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_RUN: if (run_end) begin
          st <= S_IDLE;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int N        = 4,
  parameter int RUN_CYC  = 5000,
  parameter bit USE_DONE = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] task_done,
  input logic [N-1:0] task_trig,
  input logic [N-1:0] task_busy
);
  localparam int CW = $clog2(RUN_CYC + 2);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (task_busy != '0) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (task_busy == '0 && task_trig == '0));

  p_busy_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(task_busy));

  p_trig_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(task_trig));

  p_trig_single_r3: assert property (@(posedge clk) disable iff (rst)
    (task_trig != '0) |=> (task_trig == '0));

  p_busy_starts_with_trig_r3: assert property (@(posedge clk) disable iff (rst)
    (task_busy == '0) |=> (task_busy == '0 || task_busy == task_trig));

  p_no_preempt_r8: assert property (@(posedge clk) disable iff (rst)
    (task_busy != '0) |=> (task_busy == '0 || task_busy == $past(task_busy)));

  generate
    if (USE_DONE) begin : g_done
      p_foreign_done_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (task_busy != '0 && (task_done & task_busy) == '0) |=> (task_busy == $past(task_busy)));
    end else begin : g_count
      p_run_len_r4: assert property (@(posedge clk) disable iff (rst)
        (task_busy != '0) |-> (run_len < CW'(RUN_CYC)));
    end
  endgenerate
endmodule

bind irq_dispatch irq_dispatch_chk #(.N(N), .RUN_CYC(RUN_CYC), .USE_DONE(USE_DONE)) u_chk (
  .clk(clk), .rst(rst), .task_done(task_done),
  .task_trig(task_trig), .task_busy(task_busy)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
  localparam int N = 4, LAT = 3, RUN = 5;
  localparam int NV = 6;
  localparam logic [N-1:0] VEC [NV] = '{4'b0001, 4'b1000, 4'b0110, 4'b1111, 4'b1010, 4'b0101};

  logic clk = 0, rst = 1;
  logic [N-1:0] irq = '0, irq_d = '0, done_d = '0;
  logic [N-1:0] trig, busy, trig_d, busy_d;
  int cyc = 0, checks = 0, fails = 0, busy_cnt = 0, nlog = 0;
  int log_idx [256];
  int log_cyc [256];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_dispatch #(.N(N), .LAT_CYC(LAT), .RUN_CYC(RUN), .USE_DONE(1'b0)) dut (
    .clk(clk), .rst(rst), .irq(irq), .task_done('0), .task_trig(trig), .task_busy(busy));
  irq_dispatch #(.N(N), .LAT_CYC(LAT), .RUN_CYC(RUN), .USE_DONE(1'b1)) dut_d (
    .clk(clk), .rst(rst), .irq(irq_d), .task_done(done_d), .task_trig(trig_d), .task_busy(busy_d));

  always @(negedge clk) begin
    if (busy != '0) busy_cnt <= busy_cnt + 1;
    if (trig != '0 && nlog < 256) begin
      for (int i = 0; i < N; i++) if (trig[i]) log_idx[nlog] <= i;
      log_cyc[nlog] <= cyc;
      nlog <= nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic to_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m, output int s);
    @(negedge clk); irq = m; s = cyc;
    @(negedge clk); irq = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int s, base, bc, k;
    repeat (3) @(negedge clk);
    chk(trig == '0 && busy == '0, "R1 reset outputs", int'(trig | busy), 0);
    chk(trig_d == '0 && busy_d == '0, "R1 reset outputs done mode", int'(trig_d | busy_d), 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // table walk: R2, R4, R6
    for (int v = 0; v < NV; v++) begin
      base = nlog; bc = busy_cnt;
      pulse(VEC[v], s);
      to_cyc(s + 4 * (LAT + RUN + 1) + LAT + 6);
      chk(nlog - base == $countones(VEC[v]), "R6 trigger count", nlog - base, $countones(VEC[v]));
      k = 0;
      for (int b = 0; b < N; b++) if (VEC[v][b]) begin
        if (base + k < nlog) begin
          chk(log_idx[base + k] == b, "R6 priority order", log_idx[base + k], b);
          if (k == 0)
            chk(log_cyc[base] == s + LAT + 2, "R2 dispatch latency", log_cyc[base] - s, LAT + 2);
          else
            chk(log_cyc[base + k] - log_cyc[base + k - 1] == RUN + LAT + 1, "R4 trigger spacing",
                log_cyc[base + k] - log_cyc[base + k - 1], RUN + LAT + 1);
        end
        k++;
      end
      chk(busy_cnt - bc == RUN * $countones(VEC[v]), "R4 busy cycles", busy_cnt - bc, RUN * $countones(VEC[v]));
    end

    // R8: no preemption
    base = nlog;
    pulse(4'b0100, s);
    to_cyc(s + 6); irq = 4'b0001;
    @(negedge clk); irq = '0;
    to_cyc(s + 8);
    chk(busy == 4'b0100, "R8 busy kept", busy, 4'b0100);
    to_cyc(s + 20);
    chk(nlog - base == 2, "R8 trigger count", nlog - base, 2);
    if (nlog - base == 2) begin
      chk(log_idx[base + 1] == 0, "R8 waiting source", log_idx[base + 1], 0);
      chk(log_cyc[base + 1] == s + 14, "R8 waits for run end", log_cyc[base + 1] - s, 14);
    end

    // R9 merge and R10 re-queue
    base = nlog;
    pulse(4'b0001, s);
    to_cyc(s + 6); irq = 4'b0010;
    @(negedge clk); irq = 4'b0001;
    @(negedge clk); irq = 4'b0010;
    @(negedge clk); irq = '0;
    to_cyc(s + 40);
    chk(nlog - base == 3, "R9 merged trigger count", nlog - base, 3);
    if (nlog - base == 3) begin
      chk(log_idx[base + 1] == 0 && log_cyc[base + 1] == s + 14, "R10 re-queued own source",
          log_cyc[base + 1] - s, 14);
      chk(log_idx[base + 2] == 1 && log_cyc[base + 2] == s + 23, "R9 single merged dispatch",
          log_cyc[base + 2] - s, 23);
    end

    // R5: done mode
    @(negedge clk); irq_d = 4'b0011; s = cyc;
    @(negedge clk); irq_d = '0;
    to_cyc(s + 5);
    chk(trig_d == 4'b0001 && busy_d == 4'b0001, "R5 trigger done mode", trig_d, 4'b0001);
    to_cyc(s + 7); done_d = 4'b0010;
    @(negedge clk); done_d = '0;
    to_cyc(s + 10);
    chk(busy_d == 4'b0001, "R5 busy beyond count and foreign done", busy_d, 4'b0001);
    done_d = 4'b0001;
    @(negedge clk); done_d = '0;
    chk(busy_d == '0, "R5 busy ends after own done", busy_d, 0);
    to_cyc(s + 15);
    chk(trig_d == 4'b0010, "R5 next source after done", trig_d, 4'b0010);
    to_cyc(s + 17); done_d = 4'b0010;
    @(negedge clk); done_d = '0;

    // R1: reset drops pending work
    base = nlog;
    pulse(4'b0011, s);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk(busy == '0 && trig == '0, "R1 outputs after reset", int'(busy | trig), 0);
    repeat (30) @(negedge clk);
    chk(nlog == base, "R1 pending cleared", nlog - base, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule